// File: doc/BRIEF.md
# Paged Program Counter with Three-Byte Call and Return Sequencer

This block keeps the 24-bit program counter of an 8-bit processor core whose code space is split into 64 KB pages. The upper PC byte is a page latch and not a counter. A separate address-page value loads it whenever a jump or call is taken. Sequential fetch only moves the low 16 bits, so code wraps inside its own page.

The block runs five kinds of flow change: long jump, long call, short (11-bit) call, return (plain or from interrupt), and interrupt entry. Calls and interrupt entry save the whole 24-bit PC as a three-byte frame. Returns reload it from such a frame. The frame moves one byte per cycle through an 8-bit stack port addressed by an internal stack pointer. Decoded opcodes arrive on a one-cycle strobe together with two operand bytes. An interrupt request arrives with a 16-bit vector. While a sequence runs, `busy` is high and every new request is dropped. The stack memory is external. Its read data must follow the stack address in the same cycle, so the memory is read asynchronously.

Top module: `pc_pager_unit`

## Requirements
- R1: After reset, `pc_out` is 000000h, `busy` and `stk_we` are 0, and `stk_addr` shows the stack pointer value 07h. When no transfer runs, `stk_addr` always shows the current stack pointer.
- R2: A `pc_step` pulse while idle adds one to PC[15:0]. A step from offset FFFFh gives 0000h and leaves PC[23:16] unchanged.
- R3: Opcode 02h (long jump) takes 4 cycles counted from the strobe cycle. It writes nothing to the stack and ends with PC = {`addr_page`, `op_arg_hi`, `op_arg_lo`}.
- R4: Opcode 12h (long call) takes 5 cycles. It first adds 3 to PC[15:0], then pushes the frame, and ends with PC = {`addr_page`, `op_arg_hi`, `op_arg_lo`}.
- R5: A frame push writes PC[7:0], then PC[15:8], then PC[23:16], on consecutive cycles. Each byte goes to the stack pointer plus one, so the stack pointer rises by 3 overall.
- R6: An opcode whose bits 4..0 are 10001 is a short call and takes 4 cycles. It adds 2 to PC[15:0] and pushes the frame. The final PC keeps the advanced PC[15:11], takes PC[10:8] from opcode bits 7..5 and PC[7:0] from `op_arg_lo`, and loads the page from `addr_page`.
- R7: Opcodes 22h and 32h (returns) take 5 cycles. Each reads the page byte at the stack pointer, then the high byte at the pointer minus one, then the low byte at the pointer minus two, and lowers the stack pointer by 3. The page byte restored is the one that was saved, whatever `addr_page` holds.
- R8: An accepted interrupt takes 5 cycles. It pushes the PC without any advance and ends with PC = {00h, `irq_vec`}, whatever `addr_page` holds.
- R9: While `busy` is high, `op_valid`, `irq_req` and `pc_step` have no effect, `pc_out` holds its value, and the PC changes only on the edge where `busy` falls.
- R10: If `irq_req` and `op_valid` are both high in an idle cycle, the interrupt is taken and the opcode is discarded.
- R11: A strobed opcode outside the five encodings above is ignored. `busy` stays low and neither the PC nor the stack pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle strobe for a decoded opcode |
| op_code | input | 8 | Opcode byte |
| op_arg_hi | input | 8 | First operand byte (target bits 15..8) |
| op_arg_lo | input | 8 | Last operand byte (target bits 7..0) |
| addr_page | input | 8 | Current address-page register value |
| pc_step | input | 1 | Sequential fetch advance |
| irq_req | input | 1 | Interrupt entry request |
| irq_vec | input | 16 | Interrupt vector offset within page zero |
| stk_rdata | input | 8 | Stack read data for the address on `stk_addr` |
| pc_out | output | 24 | Program counter |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |
| stk_we | output | 1 | Stack write enable |
| busy | output | 1 | Sequence in progress |

## Verification
An accepted strobe or interrupt raises `busy` on the next edge. Short call and long jump then keep it high for 3 cycles, and long call, return and interrupt entry for 4. The final PC appears on the same edge where `busy` falls. Stack writes appear in the busy cycles that carry the push, one byte per cycle. A step changes the PC on the edge right after its cycle. The monitor samples on falling clock edges. It counts the busy cycles and compares that count and the PC seen in the first idle cycle with a queued expectation. Each write-enabled cycle is matched against the next queued address and data pair.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int BYTE_W  = 8;
  localparam int PAGE_W  = BYTE_W;
  localparam int OFS_W   = 2 * BYTE_W;
  localparam int PC_W    = PAGE_W + OFS_W;
  localparam int FRAME_N = PC_W / BYTE_W;
  localparam int CNT_W   = 3;
  localparam int SHORT_W = 11;

  localparam logic [BYTE_W-1:0] OPC_LJMP  = 8'h02;
  localparam logic [BYTE_W-1:0] OPC_LCALL = 8'h12;
  localparam logic [BYTE_W-1:0] OPC_RET   = 8'h22;
  localparam logic [BYTE_W-1:0] OPC_RETI  = 8'h32;
  localparam logic [4:0]        SCALL_LOW = 5'b10001;

  typedef enum logic [2:0] {
    K_NONE, K_SCALL, K_LCALL, K_LJMP, K_RET, K_IRQ
  } kind_e;

  // index of the final busy cycle of each sequence
  function automatic logic [CNT_W-1:0] seq_last(kind_e k);
    case (k)
      K_SCALL, K_LJMP:        seq_last = CNT_W'(2);
      K_LCALL, K_RET, K_IRQ:  seq_last = CNT_W'(3);
      default:                seq_last = '0;
    endcase
  endfunction

  function automatic logic is_push(kind_e k);
    is_push = (k == K_SCALL) || (k == K_LCALL) || (k == K_IRQ);
  endfunction

  // busy cycle in which the first frame byte is written
  function automatic logic [CNT_W-1:0] push_base(kind_e k);
    push_base = (k == K_SCALL) ? CNT_W'(0) : CNT_W'(1);
  endfunction
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
(
  input  logic              valid,
  input  logic [BYTE_W-1:0] opcode,
  output kind_e             kind,
  output logic [1:0]        adv
);
  always_comb begin
    kind = K_NONE;
    adv  = 2'd0;
    if (valid) begin
      case (opcode)
        OPC_LCALL: begin kind = K_LCALL; adv = 2'd3; end
        OPC_LJMP:  kind = K_LJMP;
        OPC_RET,
        OPC_RETI:  kind = K_RET;
        default: begin
          if (opcode[4:0] == SCALL_LOW) begin
            kind = K_SCALL;
            adv  = 2'd2;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pcu_sequencer.sv
module pcu_sequencer
  import pcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [OFS_W-1:0]  irq_vec,
  input  kind_e             dec_kind,
  input  logic [BYTE_W-1:0] op_code,
  input  logic [BYTE_W-1:0] arg_hi,
  input  logic [BYTE_W-1:0] arg_lo,
  input  logic [PAGE_W-1:0] page_in,
  output logic              busy,
  output logic              acc_op,
  output logic              acc_any,
  output kind_e             kind_cur,
  output logic [OFS_W-1:0]  tgt,
  output logic [PAGE_W-1:0] pg,
  output logic              push_en,
  output logic              pop_en,
  output logic [1:0]        idx,
  output logic              finish
);
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  kind_e             kind_q, kind_d;
  logic [OFS_W-1:0]  tgt_q, tgt_d;
  logic [PAGE_W-1:0] pg_q, pg_d;
  logic              take_irq, take_op, reg_en;
  logic [CNT_W-1:0]  base, rel;

  assign take_irq = irq_req & ~busy_q;
  assign take_op  = ~busy_q & ~irq_req & (dec_kind != K_NONE);
  assign finish   = busy_q & (cnt_q == seq_last(kind_q));
  assign reg_en   = take_irq | take_op | busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    tgt_d  = tgt_q;
    pg_d   = pg_q;
    if (take_irq) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = K_IRQ;
      tgt_d  = irq_vec;
      pg_d   = '0;
    end else if (take_op) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = dec_kind;
      pg_d   = page_in;
      if (dec_kind == K_SCALL)
        tgt_d = {{(OFS_W-SHORT_W){1'b0}}, op_code[7:5], arg_lo};
      else
        tgt_d = {arg_hi, arg_lo};
    end else if (busy_q) begin
      if (finish) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        kind_d = K_NONE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= K_NONE;
      tgt_q  <= '0;
      pg_q   <= '0;
    end else if (reg_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      tgt_q  <= tgt_d;
      pg_q   <= pg_d;
    end
  end

  assign base    = push_base(kind_q);
  assign rel     = cnt_q - base;
  assign push_en = busy_q & is_push(kind_q) & (cnt_q >= base) &
                   (rel < CNT_W'(FRAME_N));
  assign pop_en  = busy_q & (kind_q == K_RET) & (cnt_q < CNT_W'(FRAME_N));
  assign idx     = push_en ? rel[1:0] : cnt_q[1:0];

  assign busy     = busy_q;
  assign acc_op   = take_op;
  assign acc_any  = take_op | take_irq;
  assign kind_cur = kind_q;
  assign tgt      = tgt_q;
  assign pg       = pg_q;
endmodule

// File: rtl/pcu_stack_port.sv
module pcu_stack_port
  import pcu_pkg::*;
#(
  parameter int              SP_W    = 8,
  parameter logic [SP_W-1:0] SP_INIT = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic              pop_en,
  input  logic [1:0]        idx,
  input  logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              stk_we
);
  logic [SP_W-1:0]   sp_q, sp_d;
  logic              sp_en;
  logic [BYTE_W-1:0] pc_byte [FRAME_N];

  // byte lanes of the PC, lane 0 is the lowest
  for (genvar g = 0; g < FRAME_N; g++) begin : g_lane
    assign pc_byte[g] = pc[g*BYTE_W +: BYTE_W];
  end

  assign sp_en = push_en | pop_en;

  always_comb begin
    sp_d = sp_q;
    if (push_en)     sp_d = sp_q + 1'b1;
    else if (pop_en) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_INIT;
    else if (sp_en) sp_q <= sp_d;
  end

  always_comb begin
    stk_addr  = push_en ? sp_q + 1'b1 : sp_q;
    stk_we    = push_en;
    stk_wdata = '0;
    if (push_en) begin
      case (idx)
        2'd0:    stk_wdata = pc_byte[0];
        2'd1:    stk_wdata = pc_byte[1];
        default: stk_wdata = pc_byte[2];
      endcase
    end
  end
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
  import pcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              adv_en,
  input  logic [1:0]        adv,
  input  logic              pop_en,
  input  logic [1:0]        idx,
  input  logic [BYTE_W-1:0] rdata,
  input  logic              finish,
  input  kind_e             kind,
  input  logic [OFS_W-1:0]  tgt,
  input  logic [PAGE_W-1:0] pg,
  output logic [PC_W-1:0]   pc
);
  logic [PC_W-1:0]   pc_q, pc_d, load_val;
  logic              pc_en;
  logic [BYTE_W-1:0] pop_q [FRAME_N];
  logic [OFS_W-1:0]  ofs;

  assign ofs = pc_q[OFS_W-1:0];

  // frame bytes arrive page first, low byte last
  for (genvar g = 0; g < FRAME_N; g++) begin : g_pop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pop_q[g] <= '0;
      else if (pop_en && (idx == 2'(g)))
        pop_q[g] <= rdata;
    end
  end

  always_comb begin
    case (kind)
      K_SCALL: load_val = {pg, ofs[OFS_W-1:SHORT_W], tgt[SHORT_W-1:0]};
      K_RET:   load_val = {pop_q[0], pop_q[1], pop_q[2]};
      default: load_val = {pg, tgt};
    endcase
  end

  assign pc_en = finish | adv_en | step_en;

  always_comb begin
    pc_d = pc_q;
    if (finish)       pc_d = load_val;
    else if (adv_en)  pc_d = {pc_q[PC_W-1:OFS_W], ofs + OFS_W'(adv)};
    else if (step_en) pc_d = {pc_q[PC_W-1:OFS_W], ofs + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pc_pager_unit.sv
module pc_pager_unit
  import pcu_pkg::*;
#(
  parameter int              SP_W    = 8,
  parameter logic [SP_W-1:0] SP_INIT = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  op_code,
  input  logic [7:0]  op_arg_hi,
  input  logic [7:0]  op_arg_lo,
  input  logic [7:0]  addr_page,
  input  logic        pc_step,
  input  logic        irq_req,
  input  logic [15:0] irq_vec,
  input  logic [7:0]  stk_rdata,
  output logic [23:0] pc_out,
  output logic [SP_W-1:0] stk_addr,
  output logic [7:0]  stk_wdata,
  output logic        stk_we,
  output logic        busy
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  kind_e             dec_kind, kind_cur;
  logic [1:0]        dec_adv, idx;
  logic              acc_op, acc_any, push_en, pop_en, finish, step_en;
  logic [OFS_W-1:0]  tgt;
  logic [PAGE_W-1:0] pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  pcu_decode u_dec (
    .valid  (op_valid),
    .opcode (op_code),
    .kind   (dec_kind),
    .adv    (dec_adv)
  );

  pcu_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .dec_kind (dec_kind),
    .op_code  (op_code),
    .arg_hi   (op_arg_hi),
    .arg_lo   (op_arg_lo),
    .page_in  (addr_page),
    .busy     (busy),
    .acc_op   (acc_op),
    .acc_any  (acc_any),
    .kind_cur (kind_cur),
    .tgt      (tgt),
    .pg       (pg),
    .push_en  (push_en),
    .pop_en   (pop_en),
    .idx      (idx),
    .finish   (finish)
  );

  assign step_en = pc_step & ~busy & ~acc_any;

  pcu_pc_reg u_pc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .step_en (step_en),
    .adv_en  (acc_op),
    .adv     (dec_adv),
    .pop_en  (pop_en),
    .idx     (idx),
    .rdata   (stk_rdata),
    .finish  (finish),
    .kind    (kind_cur),
    .tgt     (tgt),
    .pg      (pg),
    .pc      (pc_out)
  );

  pcu_stack_port #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_stk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .idx       (idx),
    .pc        (pc_out),
    .stk_addr  (stk_addr),
    .stk_wdata (stk_wdata),
    .stk_we    (stk_we)
  );
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            irq_req,
  input logic [23:0]     pc_out,
  input logic [SP_W-1:0] stk_addr,
  input logic            stk_we
);
  // R9
  pc_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (pc_out == $past(pc_out)));

  // R2
  page_kept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (pc_out[23:16] == $past(pc_out[23:16])));

  // R5
  push_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |-> (stk_addr == SP_W'($past(stk_addr) + 1'b1)));

  // R9
  write_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> busy);

  // R10
  irq_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !busy) |=> busy);
endmodule

bind pc_pager_unit pcu_checker #(.SP_W(SP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .busy     (busy),
  .irq_req  (irq_req),
  .pc_out   (pc_out),
  .stk_addr (stk_addr),
  .stk_we   (stk_we)
);

// File: tb/tb_pc_pager_unit.sv
module tb_pc_pager_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, pc_step = 1'b0, irq_req = 1'b0;
  logic [7:0]  op_code = '0, op_arg_hi = '0, op_arg_lo = '0, addr_page = '0;
  logic [15:0] irq_vec = '0;
  logic [7:0]  stk_rdata;
  logic [23:0] pc_out;
  logic [7:0]  stk_addr, stk_wdata;
  logic        stk_we, busy;

  always #5 clk = ~clk;

  pc_pager_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_arg_hi(op_arg_hi), .op_arg_lo(op_arg_lo), .addr_page(addr_page),
    .pc_step(pc_step), .irq_req(irq_req), .irq_vec(irq_vec),
    .stk_rdata(stk_rdata), .pc_out(pc_out), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_we(stk_we), .busy(busy)
  );

  // stack memory with asynchronous read
  logic [7:0] ram [256];
  assign stk_rdata = ram[stk_addr];
  always @(posedge clk) if (stk_we) ram[stk_addr] <= stk_wdata;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model state
  logic [23:0] ref_pc = 24'h0;
  logic [7:0]  ref_sp = 8'h07;
  logic [7:0]  ref_mem [256];

  typedef struct { logic [23:0] pc; int n; string tag; } exp_t;
  exp_t        pq[$];
  logic [15:0] wq[$];

  task automatic exp_push(input logic [7:0] b);
    ref_sp = ref_sp + 8'd1;
    ref_mem[ref_sp] = b;
    wq.push_back({ref_sp, b});
  endtask

  task automatic exp_frame();
    exp_push(ref_pc[7:0]);
    exp_push(ref_pc[15:8]);
    exp_push(ref_pc[23:16]);
  endtask

  // drive one cycle of stimulus from a falling edge
  task automatic drive(input bit irq, input bit opv, input bit stp,
                       input logic [7:0] opc, input logic [7:0] hi,
                       input logic [7:0] lo, input logic [7:0] pg,
                       input logic [15:0] vec);
    irq_req = irq; op_valid = opv; pc_step = stp; op_code = opc;
    op_arg_hi = hi; op_arg_lo = lo; addr_page = pg; irq_vec = vec;
    @(negedge clk);
    irq_req = 1'b0; op_valid = 1'b0; pc_step = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // scoreboard driver: model an opcode, queue results, apply it
  task automatic do_op(input logic [7:0] opc, input logic [7:0] hi,
                       input logic [7:0] lo, input logic [7:0] pg);
    exp_t e;
    if (opc == 8'h12) begin                      // R4
      ref_pc[15:0] = ref_pc[15:0] + 16'd3;
      exp_frame();
      ref_pc = {pg, hi, lo};
      e = '{ref_pc, 4, "R4"};
    end else if (opc == 8'h02) begin             // R3
      ref_pc = {pg, hi, lo};
      e = '{ref_pc, 3, "R3"};
    end else if (opc == 8'h22 || opc == 8'h32) begin  // R7
      ref_pc[23:16] = ref_mem[ref_sp]; ref_sp = ref_sp - 8'd1;
      ref_pc[15:8]  = ref_mem[ref_sp]; ref_sp = ref_sp - 8'd1;
      ref_pc[7:0]   = ref_mem[ref_sp]; ref_sp = ref_sp - 8'd1;
      e = '{ref_pc, 4, "R7"};
    end else begin                               // R6
      ref_pc[15:0] = ref_pc[15:0] + 16'd2;
      exp_frame();
      ref_pc = {pg, ref_pc[15:11], opc[7:5], lo};
      e = '{ref_pc, 3, "R6"};
    end
    pq.push_back(e);
    drive(1'b0, 1'b1, 1'b0, opc, hi, lo, pg, 16'h0);
    wait_idle();
  endtask

  task automatic do_irq(input logic [15:0] vec, input logic [7:0] pg,
                        input bit with_op);
    exp_t e;
    exp_frame();
    ref_pc = {8'h00, vec};
    e = '{ref_pc, 4, with_op ? "R10" : "R8"};
    pq.push_back(e);
    drive(1'b1, with_op, 1'b0, 8'h12, 8'h55, 8'h66, pg, vec);
    wait_idle();
  endtask

  // monitor: compare writes and completed sequences as they appear
  int  bcnt = 0;
  bit  was_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stk_we) begin
        if (wq.size() == 0) begin
          chk(1'b0, "R5", "unexpected write", {stk_addr, stk_wdata}, 32'h0);
        end else begin
          logic [15:0] w;
          w = wq.pop_front();
          chk({stk_addr, stk_wdata} == w, "R5", "push addr/data",
              {stk_addr, stk_wdata}, w);
        end
      end
      if (busy) begin
        bcnt++;
      end else if (was_busy) begin
        if (pq.size() == 0) begin
          chk(1'b0, "R9", "unexpected sequence", pc_out, 32'h0);
        end else begin
          exp_t e;
          e = pq.pop_front();
          chk(pc_out == e.pc, e.tag, "final pc", pc_out, e.pc);
          chk(bcnt == e.n, e.tag, "busy cycles", bcnt, e.n);
        end
        bcnt = 0;
      end
      was_busy = busy;
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    chk(1'b0, "R9", "watchdog", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 8'h0; ref_mem[i] = 8'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(pc_out == 24'h0, "R1", "reset pc", pc_out, 24'h0);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(stk_we == 1'b0, "R1", "reset we", stk_we, 0);
    chk(stk_addr == 8'h07, "R1", "reset sp", stk_addr, 8'h07);

    // R2 sequential steps
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, 1'b1, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0);
      ref_pc[15:0] = ref_pc[15:0] + 16'd1;
    end
    chk(pc_out == ref_pc, "R2", "step", pc_out, ref_pc);

    do_op(8'h02, 8'h80, 8'h00, 8'h12);           // long jump
    do_op(8'h12, 8'h43, 8'h21, 8'h34);           // long call
    do_op(8'hB1, 8'h00, 8'h77, 8'h56);           // short call
    do_irq(16'h0033, 8'h99, 1'b0);               // R8 page forced to zero
    do_op(8'h32, 8'h00, 8'h00, 8'hAA);           // R7 return from interrupt
    chk(stk_addr == ref_sp, "R7", "sp after reti", stk_addr, ref_sp);
    do_op(8'h22, 8'h00, 8'h00, 8'hAA);
    do_op(8'h22, 8'h00, 8'h00, 8'hAA);
    chk(stk_addr == 8'h07, "R7", "sp back to start", stk_addr, 8'h07);

    // R2 rollover inside page
    do_op(8'h02, 8'hFF, 8'hFF, 8'h05);
    drive(1'b0, 1'b0, 1'b1, 8'h0, 8'h0, 8'h0, 8'h0, 16'h0);
    ref_pc = 24'h050000;
    chk(pc_out == ref_pc, "R2", "rollover", pc_out, ref_pc);

    // R10 interrupt wins over opcode
    do_irq(16'h0100, 8'h44, 1'b1);
    do_op(8'h22, 8'h00, 8'h00, 8'h44);

    // R9 requests during a sequence are dropped
    begin
      exp_t e;
      ref_pc[15:0] = ref_pc[15:0] + 16'd3;
      exp_frame();
      ref_pc = {8'h21, 8'h10, 8'h20};
      e = '{ref_pc, 4, "R9"};
      pq.push_back(e);
      drive(1'b0, 1'b1, 1'b0, 8'h12, 8'h10, 8'h20, 8'h21, 16'h0);
      drive(1'b1, 1'b1, 1'b1, 8'h02, 8'hEE, 8'hEE, 8'hEE, 16'hBEEF);
      drive(1'b1, 1'b1, 1'b1, 8'h02, 8'hEE, 8'hEE, 8'hEE, 16'hBEEF);
      wait_idle();
      @(negedge clk);
      chk(busy == 1'b0, "R9", "no late start", busy, 0);
      chk(pc_out == ref_pc, "R9", "pc after noise", pc_out, ref_pc);
    end
    do_op(8'h22, 8'h00, 8'h00, 8'h00);

    // R11 unknown opcode
    drive(1'b0, 1'b1, 1'b0, 8'hA5, 8'h12, 8'h34, 8'h56, 16'h0);
    chk(busy == 1'b0, "R11", "busy", busy, 0);
    chk(pc_out == ref_pc, "R11", "pc", pc_out, ref_pc);
    chk(stk_addr == ref_sp, "R11", "sp", stk_addr, ref_sp);

    repeat (3) @(negedge clk);
    chk(wq.size() == 0, "R5", "pending writes", wq.size(), 0);
    chk(pq.size() == 0, "R9", "pending sequences", pq.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule